// File: doc/BRIEF.md
# Pre-Trigger Sample History Buffer

This block keeps a rolling record of the most recent sample points of a four-channel signal capture, so that the data leading up to a trigger event can still be delivered after that event. Each sample point arrives as a one-cycle strobe carrying four 32-bit channel words, together with a flag from the trigger evaluator. The block writes every sample of an armed capture into a block RAM. Read and write counters address that RAM, and the read counter trails the write counter.

Before the trigger, reads only take place once the buffer holds a full history. They retire the oldest entry just before it is overwritten, and their data is thrown away. From the trigger sample onward, every sample point reads out the oldest stored entry and presents it downstream one cycle later. The output is therefore the captured stream delayed by the depth of history held when the trigger fired. A start command clears both counters and arms the block. A stop command clears them and returns the block to idle.

Top module: `pretrig_history`

## Requirements
- R1: While reset is asserted and after it is released, `hist_valid_o` is low until a triggered read takes place.
- R2: While the block is idle (before any start, or after a stop), sample strobes are not stored and produce no output.
- R3: Before the trigger has fired, `hist_valid_o` stays low whatever is read out internally.
- R4: If the trigger fires before HIST_DEPTH samples have been written, the first emitted word set is the first sample written since the start. If no sample has been stored yet, nothing is emitted on the trigger sample itself, and output begins with the next sample.
- R5: If the trigger fires after at least HIST_DEPTH samples have been written, each emitted word set is the sample written exactly HIST_DEPTH sample points before the current one.
- R6: `hist_valid_o` is high exactly in the cycle after a sample strobe that caused a triggered read, and `hist_data_o` then holds that read. Channel 0 is in bits [31:0], and channel k is in bits [32k+31:32k].
- R7: After the trigger, every further sample strobe emits exactly one stored sample, in write order, with no gap and no repeat.
- R8: A stop command clears the write and read counters and the trigger state. Samples written before the stop are never emitted afterwards.
- R9: A start command received while a capture is running restarts it with empty history and the trigger cleared.
- R10: When start and stop are asserted in the same cycle, stop wins and the block ends idle. In a start or stop cycle the sample strobe is ignored.
- R11: The trigger flag is acted on only in a cycle with a sample strobe while the block is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command: clear counters and arm |
| stop_i | input | 1 | Stop command: clear counters and disarm |
| sample_i | input | 1 | Sample-point strobe |
| trig_hit_i | input | 1 | Trigger condition met at this sample point |
| chan_data_i | input | NUM_CH*CH_W | Four channel words, channel 0 in the low bits |
| hist_valid_o | output | 1 | Emitted history sample valid |
| hist_data_o | output | NUM_CH*CH_W | Emitted history sample |

## Verification
The inline properties check the following on every cycle:
- the output strobe only ever follows a sample strobe of an armed capture;
- no output appears before the trigger;
- a full, untriggered buffer keeps its read counter equal to its write counter;
- a stop always leaves both counters at zero;
- both counters stay inside the history depth.

Only the bench scenarios can show that the data emitted is the right sample in the right order. They do this by comparing each cycle against a queue model, across the following cases:
- a trigger into an empty buffer;
- a trigger into a partly filled buffer;
- a trigger after the buffer has wrapped several times;
- a restart, a stop, and simultaneous start and stop.

// File: rtl/histring_pkg.sv
package histring_pkg;
  localparam int unsigned NUM_CH_DEF = 4;
  localparam int unsigned CH_W_DEF   = 32;
  localparam int unsigned DEPTH_DEF  = 100;
endpackage

// File: rtl/histring_ptr.sv
module histring_ptr #(
  parameter int unsigned DEPTH = 100,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (clr_i)  ptr_q <= '0;
    else if (adv_i)  ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  p_ptr_in_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST);

  p_clr_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ptr_q == '0);
endmodule

// File: rtl/histring_mem.sv
module histring_mem #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CH_W   = 32,
  parameter int unsigned DEPTH  = 100,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk_i,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [NUM_CH*CH_W-1:0] wdata_i,
  input  logic                   re_i,
  input  logic [AW-1:0]          raddr_i,
  output logic [NUM_CH*CH_W-1:0] rdata_o
);
  // one RAM per channel; read-first so a full buffer returns the entry being overwritten
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CH_W-1:0] mem [DEPTH];
    logic [CH_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i) mem[waddr_i] <= wdata_i[c*CH_W +: CH_W];
      if (re_i) rd_q <= mem[raddr_i];
    end

    assign rdata_o[c*CH_W +: CH_W] = rd_q;
  end
endmodule

// File: rtl/pretrig_history.sv
module pretrig_history
  import histring_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_DEF,
  parameter int unsigned CH_W   = CH_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned SW    = NUM_CH * CH_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          sample_i,
  input  logic          trig_hit_i,
  input  logic [SW-1:0] chan_data_i,
  output logic          hist_valid_o,
  output logic [SW-1:0] hist_data_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic armed_q, fired_q, full_q, valid_q;
  logic cmd, act, hit, empty, wr_en, rd_en;
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign cmd   = start_i | stop_i;
  assign act   = armed_q & sample_i & ~cmd;
  assign hit   = fired_q | trig_hit_i;
  assign empty = ~full_q & (wr_ptr == '0);
  assign wr_en = act;
  assign rd_en = act & (full_q | hit) & ~empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      fired_q <= 1'b0;
      full_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_en & hit;
      if (cmd) begin
        armed_q <= ~stop_i;
        fired_q <= 1'b0;
        full_q  <= 1'b0;
      end else if (act) begin
        if (trig_hit_i)       fired_q <= 1'b1;
        if (wr_ptr == LAST)   full_q  <= 1'b1;
      end
    end
  end

  histring_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (cmd), .adv_i (wr_en), .ptr_o (wr_ptr)
  );

  histring_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (cmd), .adv_i (rd_en), .ptr_o (rd_ptr)
  );

  histring_mem #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (wr_ptr),
    .wdata_i (chan_data_i),
    .re_i    (rd_en),
    .raddr_i (rd_ptr),
    .rdata_o (hist_data_o)
  );

  assign hist_valid_o = valid_q;

  p_valid_after_sample_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_valid_o |-> $past(sample_i & armed_q & ~start_i & ~stop_i));

  p_quiet_before_trig_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~fired_q & ~(trig_hit_i & sample_i)) |=> ~hist_valid_o);

  p_full_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q & ~fired_q) |-> (rd_ptr == wr_ptr));

  p_stop_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (~armed_q & ~hist_valid_o & wr_ptr == '0 & rd_ptr == '0));

  p_idle_silent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ~armed_q |=> ~hist_valid_o);
endmodule

// File: tb/pretrig_history_test.sv
`timescale 1ns/1ps
module pretrig_history_test;
  localparam int NCH = 4;
  localparam int CW  = 32;
  localparam int DEP = 100;
  localparam int SW  = NCH * CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, smp = 1'b0, trg = 1'b0;
  logic [SW-1:0] din = '0;
  logic hv;
  logic [SW-1:0] hd;

  always #4 clk = ~clk;

  pretrig_history uut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .stop_i (stop),
    .sample_i (smp), .trig_hit_i (trg), .chan_data_i (din),
    .hist_valid_o (hv), .hist_data_o (hd)
  );

  int total_chk = 0, bad_chk = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model
  bit m_armed = 0, m_fired = 0;
  int m_total = 0;
  logic [SW-1:0] q[$];
  bit exp_v = 0;
  logic [SW-1:0] exp_d = '0;
  int seq = 0;

  function automatic logic [SW-1:0] mk(input int n);
    logic [SW-1:0] r;
    for (int j = 0; j < NCH; j++) r[j*CW +: CW] = 32'hA500_0000 + 32'(n * 16 + j);
    return r;
  endfunction

  task automatic check_out();
    total_chk++;
    if (hv !== exp_v) begin
      bad_chk++;
      $display("FAIL %s valid: actual=%b expected=%b", tag, hv, exp_v);
    end else if (exp_v) begin
      total_chk++;
      if (hd !== exp_d) begin
        bad_chk++;
        $display("FAIL %s data: actual=%h expected=%h", tag, hd, exp_d);
      end
    end
  endtask

  task automatic step(input bit st, input bit sp, input bit s, input bit t);
    logic [SW-1:0] d;
    bit h;
    @(negedge clk);
    check_out();
    d = mk(seq);
    seq++;
    start = st; stop = sp; smp = s; trg = t; din = d;
    exp_v = 0;
    if (sp) begin
      m_armed = 0; m_fired = 0; m_total = 0; q.delete();
    end else if (st) begin
      m_armed = 1; m_fired = 0; m_total = 0; q.delete();
    end else if (m_armed && s) begin
      h = m_fired | t;
      if ((m_total >= DEP || h) && q.size() > 0) begin
        logic [SW-1:0] x;
        x = q.pop_front();
        if (h) begin exp_v = 1; exp_d = x; end
      end
      q.push_back(d);
      m_total++;
      if (t) m_fired = 1;
    end
  endtask

  task automatic run(input int n, input bit t, input int gap);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 1, t);
      for (int g = 0; g < gap; g++) step(0, 0, 0, 1);  // trigger flag without strobe: R11
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    check_out();
    rst_n = 1'b1;
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    tag = "R2";                 // idle samples with trigger: nothing
    run(5, 1, 0);

    tag = "R4";                 // partial fill then trigger
    step(1, 0, 1, 1);           // start cycle ignores strobe (R10)
    run(6, 0, 1);
    tag = "R3";
    run(3, 0, 0);
    tag = "R4";
    step(0, 0, 1, 1);
    tag = "R7";
    run(12, 0, 2);

    tag = "R8";
    step(0, 1, 1, 1);
    run(6, 1, 0);

    tag = "R4";                 // trigger into empty buffer
    step(1, 0, 0, 0);
    step(0, 0, 1, 1);
    run(8, 0, 0);

    tag = "R9";                 // restart while running, then wrap several times
    step(1, 0, 0, 0);
    tag = "R3";
    run(250, 0, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1);
    tag = "R5";
    step(0, 0, 1, 1);
    run(40, 0, 1);

    tag = "R10";
    step(1, 1, 1, 1);
    run(8, 1, 0);

    tag = "R6";                 // exactly DEP samples, trigger on the next
    step(1, 0, 0, 0);
    run(DEP, 0, 0);
    step(0, 0, 1, 1);
    run(5, 0, 3);

    tag = "R7";                 // mixed strobe pattern after trigger
    for (int i = 0; i < 60; i++) step(0, 0, (i % 3) != 1, i[0]);
    step(0, 1, 0, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad_chk++;
      total_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
    end
  end
endmodule